// File: doc/BRIEF.md
# Rollover Timer with Interrupt

This block is a free-running counter with a small configuration register. Each count step comes from one of two sources. One source is every cycle of the system clock. The other is a chosen edge, rising or falling, on an external input pin. The block synchronises that pin internally. When the counter wraps from all ones back to zero, a pending flag is set. The flag stays set until software strobes a clear.

An interrupt request is the pending flag gated by an enable bit. The enable bit is active-low and comes out of reset disabled. Software can read the counter at any time and can load it with a new value. A loaded counter reaches the next wrap after a known number of steps, which gives periodic events at fixed, deterministic intervals.

Top module: `rto_timer`

## Requirements
- R1: After reset the counter reads 0 and `irq` is 0. The configuration register resets to 3'b111: interrupts are masked, the clock cycle is the count source and the rising edge is selected. The counter therefore counts clock cycles straight out of reset.
- R2: When `cfg_wdata[1]` (the source bit) is 1, the counter advances by exactly one on every clock cycle in which no counter load occurs.
- R3: The counter wraps from 8'hFF to 8'h00. The pending flag sets on the same clock edge at which the counter becomes 8'h00. This holds in both count-source modes.
- R4: `irq` equals the pending flag ANDed with the inverse of `cfg_wdata[2]` (the mask bit, 1 = masked). Setting the mask forces `irq` low.
- R5: The pending flag still sets on a wrap while interrupts are masked. Clearing the mask afterwards raises `irq` at once.
- R6: A one-cycle `pend_clr` strobe clears the pending flag, and `irq` falls on the next clock edge.
- R7: If `pend_clr` is asserted in the same cycle as a wrap, the pending flag stays set.
- R8: When the source bit is 0 and `cfg_wdata[0]` (the edge bit) is 1, each low-to-high transition of `ext_pin` adds exactly one count. The count appears on the third rising clock edge after the pin changes. High-to-low transitions add nothing.
- R9: When the source bit is 0 and the edge bit is 0, each high-to-low transition of `ext_pin` adds exactly one count. Low-to-high transitions add nothing.
- R10: When the source bit is 0 and `ext_pin` is steady, the counter holds its value.
- R11: A cycle with `cnt_we` high loads `cnt_wdata` into the counter and suppresses counting for that cycle. A load of 8'h00 from 8'hFF is not a wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Asynchronous external count input |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 3 | Configuration data: [2] interrupt mask (1 = masked), [1] source (1 = clock), [0] edge (1 = rising) |
| cnt_we | input | 1 | Counter load strobe |
| cnt_wdata | input | CNT_W | Counter load value |
| pend_clr | input | 1 | Pending flag clear strobe |
| cnt_rdata | output | CNT_W | Current counter value |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit counter and a two-stage synchroniser. With the 8-bit width, loading 8'hFD or 8'hFF brings a wrap within a few cycles. This makes the collision of a clear strobe with a wrap easy to place on an exact edge. The two-stage synchroniser fixes the pin-to-count latency at three edges, so the bench samples one edge early to confirm nothing arrives too soon and again at the exact edge. Each edge mode is driven with both polarities of transition to show that the wrong edge is ignored.

// File: rtl/rto_pkg.sv
package rto_pkg;

    localparam int CFG_W = 3;

    typedef struct packed {
        logic irq_mask;      // 1 = interrupt masked
        logic src_clock;     // 1 = count clock cycles, 0 = count pin edges
        logic edge_rising;   // 1 = low-to-high, 0 = high-to-low
    } cfg_t;

    localparam cfg_t CFG_RESET = '{irq_mask: 1'b1, src_clock: 1'b1, edge_rising: 1'b1};

    function automatic logic pick_tick(input cfg_t cfg, input logic rise, input logic fall);
        if (cfg.src_clock)
            return 1'b1;
        return cfg.edge_rising ? rise : fall;
    endfunction

endpackage

// File: rtl/rto_edge_det.sv
module rto_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
    assign fall = ~sync_q[STAGES-1] & prev_q;

    // R8: one pulse per transition
    p_single_rise_r8: assert property (@(posedge clk) disable iff (rst) rise |=> !rise);
    // R9: one pulse per transition
    p_single_fall_r9: assert property (@(posedge clk) disable iff (rst) fall |=> !fall);
endmodule

// File: rtl/rto_cfg_reg.sv
module rto_cfg_reg
    import rto_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg <= CFG_RESET;
        else if (we)
            cfg <= cfg_t'(wdata);
    end

    // R1: configuration leaves reset masked
    p_reset_mask_r1: assert property (@(posedge clk) rst |=> cfg.irq_mask);
endmodule

// File: rtl/rto_counter.sv
module rto_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    assign wrap = tick & ~we & (cnt == TOP);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (we)
            cnt <= wdata;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    // R11: a load wins over a tick
    p_load_r11: assert property (@(posedge clk) disable iff (rst) we |=> cnt == $past(wdata));
    // R10: no tick, no change
    p_hold_r10: assert property (@(posedge clk) disable iff (rst) (!we && !tick) |=> $stable(cnt));
    // R3: a wrap lands on zero
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (rst) wrap |=> cnt == '0);
endmodule

// File: rtl/rto_timer.sv
module rto_timer
    import rto_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_pin,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             pend_clr,
    output logic [CNT_W-1:0] cnt_rdata,
    output logic             irq
);
    cfg_t cfg;
    logic rise, fall, tick, wrap, pend_q;

    rto_cfg_reg u_cfg (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .wdata(cfg_wdata),
        .cfg  (cfg)
    );

    rto_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk (clk),
        .rst (rst),
        .pin (ext_pin),
        .rise(rise),
        .fall(fall)
    );

    assign tick = pick_tick(cfg, rise, fall);

    rto_counter #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .we   (cnt_we),
        .wdata(cnt_wdata),
        .cnt  (cnt_rdata),
        .wrap (wrap)
    );

    // a fresh wrap outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (wrap)
            pend_q <= 1'b1;
        else if (pend_clr)
            pend_q <= 1'b0;
    end

    assign irq = pend_q & ~cfg.irq_mask;

    // R3, R5: the wrap always sets pending
    p_wrap_pend_r3: assert property (@(posedge clk) disable iff (rst) wrap |=> pend_q);
    // R7: a clear colliding with a wrap keeps pending
    p_collide_r7: assert property (@(posedge clk) disable iff (rst) (wrap && pend_clr) |=> pend_q);
    // R6: a clear without a wrap drops pending
    p_clear_r6: assert property (@(posedge clk) disable iff (rst) (pend_clr && !wrap) |=> !pend_q);
    // R4: a masked configuration never requests
    p_mask_r4: assert property (@(posedge clk) disable iff (rst) cfg.irq_mask |-> !irq);
endmodule

// File: tb/rto_timer_bench.sv
module rto_timer_bench;
    import rto_pkg::*;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ext_pin = 1'b0;
    logic             cfg_we = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic             cnt_we = 1'b0;
    logic [CNT_W-1:0] cnt_wdata = '0;
    logic             pend_clr = 1'b0;
    logic [CNT_W-1:0] cnt_rdata;
    logic             irq;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    rto_timer u_rto_timer (
        .clk(clk), .rst(rst), .ext_pin(ext_pin),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .pend_clr(pend_clr), .cnt_rdata(cnt_rdata), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [2:0] v);
        cfg_wdata = v; cfg_we = 1'b1; step(1); cfg_we = 1'b0;
    endtask

    task automatic load_cnt(input logic [7:0] v);
        cnt_wdata = v; cnt_we = 1'b1; step(1); cnt_we = 1'b0;
    endtask

    task automatic clear_pend();
        pend_clr = 1'b1; step(1); pend_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; step(3);
        check("R1 count", cnt_rdata, 0);
        check("R1 irq", irq, 0);
        rst = 1'b0; step(1);
        check("R1 counts clock after reset", cnt_rdata, 1);
    endtask

    task automatic t_internal();
        step(4);
        check("R2 five cycles", cnt_rdata, 5);
    endtask

    task automatic t_wrap_masked();
        load_cnt(8'hFD);
        check("R11 load", cnt_rdata, 8'hFD);
        step(2);
        check("R3 before wrap", cnt_rdata, 8'hFF);
        check("R3 irq before wrap", irq, 0);
        step(1);
        check("R3 wrap", cnt_rdata, 0);
        check("R4 masked irq", irq, 0);
        write_cfg(3'b011);
        check("R5 unmask raises irq", irq, 1);
        write_cfg(3'b111);
        check("R4 remask drops irq", irq, 0);
        write_cfg(3'b011);
        clear_pend();
        check("R6 clear", irq, 0);
    endtask

    task automatic t_collide();
        load_cnt(8'hFE);
        step(1);
        check("R7 at top", cnt_rdata, 8'hFF);
        check("R3 irq not early", irq, 0);
        pend_clr = 1'b1; step(1); pend_clr = 1'b0;
        check("R7 wrap kept", irq, 1);
        check("R3 wrapped", cnt_rdata, 0);
        clear_pend();
        check("R6 clear after collide", irq, 0);
    endtask

    task automatic t_load();
        load_cnt(8'h40);
        check("R11 no count in load cycle", cnt_rdata, 8'h40);
        step(1);
        check("R11 resume", cnt_rdata, 8'h41);
        load_cnt(8'hFF);
        load_cnt(8'h00);
        check("R11 load zero", cnt_rdata, 0);
        check("R11 load is no wrap", irq, 0);
    endtask

    task automatic t_ext_rise();
        write_cfg(3'b001);
        load_cnt(8'h00);
        step(5);
        check("R10 steady pin holds", cnt_rdata, 0);
        ext_pin = 1'b1; step(2);
        check("R8 not early", cnt_rdata, 0);
        step(1);
        check("R8 third edge", cnt_rdata, 1);
        ext_pin = 1'b0; step(5);
        check("R8 fall ignored", cnt_rdata, 1);
        for (int i = 0; i < 3; i++) begin
            ext_pin = 1'b1; step(2); ext_pin = 1'b0; step(2);
        end
        step(2);
        check("R8 three pulses", cnt_rdata, 4);
        load_cnt(8'hFF);
        ext_pin = 1'b1; step(4); ext_pin = 1'b0; step(3);
        check("R3 ext wrap", cnt_rdata, 0);
        check("R3 ext irq", irq, 1);
        clear_pend();
    endtask

    task automatic t_ext_fall();
        write_cfg(3'b000);
        load_cnt(8'h10);
        ext_pin = 1'b1; step(5);
        check("R9 rise ignored", cnt_rdata, 8'h10);
        ext_pin = 1'b0; step(2);
        check("R9 not early", cnt_rdata, 8'h10);
        step(1);
        check("R9 fall counted", cnt_rdata, 8'h11);
        step(4);
        check("R10 hold", cnt_rdata, 8'h11);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_internal();
                t_wrap_masked();
                t_collide();
                t_load();
                t_ext_rise();
                t_ext_fall();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule